// File: doc/BRIEF.md
# Multiple Header Recording Queue

This block holds the logging state for uncorrectable errors: a pointer to the first recorded error, a four-word header log, and a four-word prefix log with its present bit. It also holds the uncorrectable status bits as write-one-to-clear storage. Each record request carries a one-hot status vector, header and prefix words, and two flags that say whether those words are valid.

When multiple header recording is enabled and the first error is still pending, a new record is not allowed to overwrite the visible log. It waits in a small FIFO instead. When software clears the first error's status bit, every queued status bit is set again and the oldest queued record becomes the visible log. If a record arrives and the FIFO is full, the record is dropped and a one-cycle overflow pulse is raised. A neighbouring block turns that pulse into a correctable header-log-overflow error.

Records enter over a valid/ready handshake. Software clears are plain single-cycle strobes and take priority: `rec_ready` is low in any cycle where `clr_valid` is high. A record presented in that cycle is held by the sender and accepted on a later cycle.

Top module: `mhr_err_log`

## Requirements
- R1: An accepted record that is loaded into the log sets `fep` to the bit index of its single set status bit. Bit i of `rec_status` maps to status bit i and to `fep` value i. The next cycle, that bit is set in `unc_status`.
- R2: The header log takes `rec_hdr` (word 0 in bits 31:0) when `rec_hdr_vld` is 1 and becomes zero otherwise. The sender must not raise `rec_pfx_vld` without `rec_hdr_vld`.
- R3: The prefix log takes `rec_pfx`, and `pfx_present` becomes 1, only when both `rec_pfx_vld` and `pfx_sup` are 1. Otherwise the prefix log is zero and `pfx_present` is 0.
- R4: With `mhr_en` high and `unc_status[fep]` set, an accepted record is queued and the visible log is unchanged. With `mhr_en` low, the record overwrites the log.
- R5: A record that would be queued while the FIFO holds DEPTH entries is dropped. Its status bit is still set, and `ovf_o` is high for exactly the one cycle after acceptance.
- R6: A clear that removes the first-error bit, with `mhr_en` high and a non-empty FIFO, sets again the status bits of all queued records. It then loads the oldest queued record into the log (first in, first out).
- R7: A clear that removes the first-error bit, with `mhr_en` low or the FIFO empty, zeroes `fep`, `pfx_present` and both logs.
- R8: A clear that leaves the first-error bit set has two cases:
  - With `mhr_en` high, the queued status bits are set again, so clearing a queued bit has no effect.
  - With `mhr_en` low, the FIFO is emptied.
- R9: `mhr_cap` is 1 exactly when DEPTH is greater than zero. Enabling `mhr_en` has no effect when DEPTH is zero.
- R10: `rec_ready` is 0 while `clr_valid` is 1, and a record presented then is not accepted.
- R11: After reset, `unc_status`, `fep`, both logs, `pfx_present` and `ovf_o` are all zero, and `rec_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Record request valid |
| rec_ready | output | 1 | Record accepted this cycle when valid |
| rec_status | input | 32 | One-hot uncorrectable status of the record |
| rec_hdr_vld | input | 1 | Header words are valid |
| rec_pfx_vld | input | 1 | Prefix words are valid |
| rec_hdr | input | 128 | Four header words, word 0 lowest |
| rec_pfx | input | 128 | Four prefix words, word 0 lowest |
| clr_valid | input | 1 | Software write-one-to-clear strobe |
| clr_mask | input | 32 | Status bits to clear |
| mhr_en | input | 1 | Multiple header recording enable |
| pfx_sup | input | 1 | End-to-end prefix support advertised |
| unc_status | output | 32 | Uncorrectable status bits |
| fep | output | 5 | First-error pointer |
| hdr_log | output | 128 | Logged header words |
| pfx_log | output | 128 | Logged prefix words |
| pfx_present | output | 1 | Prefix log holds valid words |
| ovf_o | output | 1 | One-cycle header-log overflow pulse |
| mhr_cap | output | 1 | Multiple header recording capability |

## Verification
The assertions take for granted two things about the inputs:
- Every presented record has exactly one status bit set.
- A record never flags prefix words without also flagging header words.

The bench builds every record from a single bit index, and sets the prefix flag only together with the header flag, so its stimulus stays inside those rules. The in-module checks also assume that the control logic never pushes into a full FIFO or pops an empty one. The overflow and back-pressure scenarios drive the block right to those edges.

// File: rtl/mhr_pkg.sv
package mhr_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NWORD  = 4;
  localparam int unsigned LOG_W  = NWORD * WORD_W;
  localparam int unsigned PTR_W  = $clog2(STAT_W);

  typedef struct packed {
    logic [STAT_W-1:0] status;
    logic              hdr_vld;
    logic              pfx_vld;
    logic [LOG_W-1:0]  hdr;
    logic [LOG_W-1:0]  pfx;
  } err_rec_t;

  // index of the lowest set bit
  function automatic logic [PTR_W-1:0] low_bit_idx(input logic [STAT_W-1:0] v);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = STAT_W - 1; i >= 0; i--) begin
      if (v[i]) r = PTR_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/mhr_fifo.sv
module mhr_fifo
  import mhr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  err_rec_t          push_rec,
  input  logic              pop,
  input  logic              flush,
  output err_rec_t          head_rec,
  output logic              empty,
  output logic              full,
  output logic [STAT_W-1:0] pend_status
);
  generate
    if (DEPTH == 0) begin : g_none
      assign head_rec    = '0;
      assign empty       = 1'b1;
      assign full        = 1'b1;
      assign pend_status = '0;
    end else begin : g_q
      localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      localparam int unsigned CNT_W = $clog2(DEPTH + 1);
      localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

      err_rec_t         mem [DEPTH];
      logic [IDX_W-1:0] wr_ptr, rd_ptr;
      logic [CNT_W-1:0] cnt;

      assign empty    = (cnt == '0);
      assign full     = (cnt == CNT_W'(DEPTH));
      assign head_rec = mem[rd_ptr];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          cnt    <= '0;
        end else if (flush) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          cnt    <= '0;
        end else begin
          if (push) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
          end
          if (pop) begin
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
          end
          if (push && !pop) cnt <= cnt + 1'b1;
          else if (pop && !push) cnt <= cnt - 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_rec;
      end

      // OR of the status of every live entry
      always_comb begin
        int off;
        pend_status = '0;
        for (int i = 0; i < DEPTH; i++) begin
          off = (i >= int'(rd_ptr)) ? i - int'(rd_ptr) : i + int'(DEPTH) - int'(rd_ptr);
          if (off < int'(cnt)) pend_status = pend_status | mem[i].status;
        end
      end

      // R5
      no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
      // R6
      no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    end
  endgenerate
endmodule

// File: rtl/mhr_log_reg.sv
module mhr_log_reg
  import mhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  err_rec_t         ld_rec,
  input  logic             wipe,
  input  logic             pfx_sup,
  output logic [PTR_W-1:0] fep,
  output logic [LOG_W-1:0] hdr_log,
  output logic [LOG_W-1:0] pfx_log,
  output logic             pfx_present
);
  logic take_pfx;
  assign take_pfx = ld_rec.pfx_vld && pfx_sup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fep         <= '0;
      hdr_log     <= '0;
      pfx_log     <= '0;
      pfx_present <= 1'b0;
    end else if (load) begin
      fep         <= low_bit_idx(ld_rec.status);
      hdr_log     <= ld_rec.hdr_vld ? ld_rec.hdr : '0;
      pfx_log     <= take_pfx ? ld_rec.pfx : '0;
      pfx_present <= take_pfx;
    end else if (wipe) begin
      fep         <= '0;
      hdr_log     <= '0;
      pfx_log     <= '0;
      pfx_present <= 1'b0;
    end
  end

  // R3
  pfx_needs_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfx_present) |-> $past(load && ld_rec.pfx_vld && pfx_sup));
endmodule

// File: rtl/mhr_err_log.sv
module mhr_err_log
  import mhr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rec_valid,
  output logic                  rec_ready,
  input  logic [STAT_W-1:0]     rec_status,
  input  logic                  rec_hdr_vld,
  input  logic                  rec_pfx_vld,
  input  logic [LOG_W-1:0]      rec_hdr,
  input  logic [LOG_W-1:0]      rec_pfx,
  input  logic                  clr_valid,
  input  logic [STAT_W-1:0]     clr_mask,
  input  logic                  mhr_en,
  input  logic                  pfx_sup,
  output logic [STAT_W-1:0]     unc_status,
  output logic [PTR_W-1:0]      fep,
  output logic [LOG_W-1:0]      hdr_log,
  output logic [LOG_W-1:0]      pfx_log,
  output logic                  pfx_present,
  output logic                  ovf_o,
  output logic                  mhr_cap
);
  localparam logic MHR_CAP = (DEPTH > 0);

  err_rec_t          in_rec, head_rec, ld_rec;
  logic              q_empty, q_full;
  logic [STAT_W-1:0] pend_status, after_clr;
  logic              mhr_on, rec_fire, queue_it, push, drop, first_gone;
  logic              promote, wipe, reassert, flush, load;

  assign mhr_cap   = MHR_CAP;
  assign mhr_on    = mhr_en && MHR_CAP;
  assign rec_ready = !clr_valid;
  assign rec_fire  = rec_valid && rec_ready;

  assign in_rec = '{status: rec_status, hdr_vld: rec_hdr_vld, pfx_vld: rec_pfx_vld,
                    hdr: rec_hdr, pfx: rec_pfx};

  // record path
  assign queue_it = rec_fire && mhr_on && unc_status[fep];
  assign push     = queue_it && !q_full;
  assign drop     = queue_it && q_full;

  // software clear path
  assign after_clr  = unc_status & ~clr_mask;
  assign first_gone = !after_clr[fep];
  assign promote    = clr_valid && first_gone && mhr_on && !q_empty;
  assign wipe       = clr_valid && first_gone && !promote;
  assign reassert   = clr_valid && mhr_on && (promote || !first_gone);
  assign flush      = clr_valid && !first_gone && !mhr_on;

  assign load   = (rec_fire && !queue_it) || promote;
  assign ld_rec = promote ? head_rec : in_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unc_status <= '0;
      ovf_o      <= 1'b0;
    end else begin
      ovf_o <= drop;
      if (rec_fire) unc_status <= unc_status | rec_status;
      else if (clr_valid) unc_status <= after_clr | (reassert ? pend_status : '0);
    end
  end

  mhr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_rec   (in_rec),
    .pop        (promote),
    .flush      (flush),
    .head_rec   (head_rec),
    .empty      (q_empty),
    .full       (q_full),
    .pend_status(pend_status)
  );

  mhr_log_reg u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .ld_rec     (ld_rec),
    .wipe       (wipe),
    .pfx_sup    (pfx_sup),
    .fep        (fep),
    .hdr_log    (hdr_log),
    .pfx_log    (pfx_log),
    .pfx_present(pfx_present)
  );

  // R1
  onehot_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> ($countones(rec_status) == 1));
  // R1
  rec_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fire |=> ((unc_status & $past(rec_status)) == $past(rec_status)));
  // R2
  pfx_needs_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_hdr_vld) |-> !rec_pfx_vld);
  // R5
  ovf_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(rec_fire && mhr_on));
  // R7
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (fep == '0 && !pfx_present && hdr_log == '0));
endmodule

// File: tb/sim_mhr_err_log.sv
module sim_mhr_err_log;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rec_valid = 1'b0, rec_hdr_vld = 1'b0, rec_pfx_vld = 1'b0;
  logic         rec_ready;
  logic [31:0]  rec_status = '0, clr_mask = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic         clr_valid = 1'b0, mhr_en = 1'b0, pfx_sup = 1'b0;
  logic [31:0]  unc_status;
  logic [4:0]   fep;
  logic [127:0] hdr_log, pfx_log;
  logic         pfx_present, ovf_o, mhr_cap;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mhr_err_log #(.DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_status(rec_status), .rec_hdr_vld(rec_hdr_vld), .rec_pfx_vld(rec_pfx_vld),
    .rec_hdr(rec_hdr), .rec_pfx(rec_pfx), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .mhr_en(mhr_en), .pfx_sup(pfx_sup), .unc_status(unc_status), .fep(fep),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .pfx_present(pfx_present),
    .ovf_o(ovf_o), .mhr_cap(mhr_cap)
  );

  function automatic logic [127:0] mk(input logic [7:0] t, input logic [7:0] k);
    return {t, k, 16'h0003, t, k, 16'h0002, t, k, 16'h0001, t, k, 16'h0000};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one accepted record; returns at the negedge after the capturing edge
  task automatic rec(input int b, input bit hv, input bit pv);
    @(negedge clk);
    rec_valid = 1'b1; rec_status = 32'(1) << b;
    rec_hdr_vld = hv; rec_pfx_vld = pv;
    rec_hdr = mk(8'hA1, 8'(b)); rec_pfx = mk(8'hB2, 8'(b));
    @(negedge clk);
    rec_valid = 1'b0; rec_hdr_vld = 1'b0; rec_pfx_vld = 1'b0;
  endtask

  task automatic clr(input logic [31:0] m);
    @(negedge clk);
    clr_valid = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset;
    chk("R11 status", unc_status, 0);
    chk("R11 fep", fep, 0);
    chk("R11 hdr", hdr_log, 0);
    chk("R11 pfx", pfx_log, 0);
    chk("R11 pfx_present", pfx_present, 0);
    chk("R11 ovf", ovf_o, 0);
    chk("R11 ready", rec_ready, 1);
    chk("R9 cap", mhr_cap, 1);
  endtask

  task automatic t_basic;
    mhr_en = 0; pfx_sup = 1;
    rec(12, 1, 1);
    chk("R1 fep", fep, 12);
    chk("R1 status", unc_status, 32'h1000);
    chk("R2 hdr", hdr_log, mk(8'hA1, 8'd12));
    chk("R3 pfx", pfx_log, mk(8'hB2, 8'd12));
    chk("R3 present", pfx_present, 1);
    clr(32'h1000);
    chk("R7 fep", fep, 0);
    chk("R7 hdr", hdr_log, 0);
    chk("R7 pfx", pfx_log, 0);
    chk("R7 present", pfx_present, 0);
    chk("R7 status", unc_status, 0);
  endtask

  task automatic t_noflags;
    mhr_en = 0; pfx_sup = 0;
    rec(5, 1, 1);
    chk("R3 no sup pfx", pfx_log, 0);
    chk("R3 no sup present", pfx_present, 0);
    chk("R2 hdr kept", hdr_log, mk(8'hA1, 8'd5));
    clr(32'h20);
    rec(7, 0, 0);
    chk("R2 hdr zero", hdr_log, 0);
    chk("R1 fep7", fep, 7);
    clr(32'h80);
  endtask

  task automatic t_overwrite;
    mhr_en = 0; pfx_sup = 1;
    rec(4, 1, 0);
    rec(9, 1, 0);
    chk("R4 off fep", fep, 9);
    chk("R4 off hdr", hdr_log, mk(8'hA1, 8'd9));
    chk("R4 off status", unc_status, 32'h210);
    clr(32'h210);
    chk("R7 off wipe", hdr_log, 0);
    chk("R7 off status", unc_status, 0);
  endtask

  task automatic t_queue;
    mhr_en = 1; pfx_sup = 1;
    rec(3, 1, 0);
    rec(10, 1, 0);
    rec(20, 1, 1);
    chk("R4 on fep", fep, 3);
    chk("R4 on hdr", hdr_log, mk(8'hA1, 8'd3));
    chk("R4 on status", unc_status, 32'h0010_0408);
    clr(32'h408);
    chk("R6 fep", fep, 10);
    chk("R6 hdr", hdr_log, mk(8'hA1, 8'd10));
    chk("R6 reassert", unc_status, 32'h0010_0400);
    clr(32'h400);
    chk("R6 fifo order fep", fep, 20);
    chk("R6 pfx", pfx_log, mk(8'hB2, 8'd20));
    chk("R6 present", pfx_present, 1);
    clr(32'h0010_0000);
    chk("R7 empty fep", fep, 0);
    chk("R7 empty present", pfx_present, 0);
    chk("R7 empty status", unc_status, 0);
  endtask

  task automatic t_ovf;
    mhr_en = 1; pfx_sup = 0;
    rec(1, 1, 0);
    rec(2, 1, 0);
    rec(6, 1, 0);
    rec(8, 1, 0);
    rec(11, 1, 0);
    chk("R5 no ovf yet", ovf_o, 0);
    rec(14, 1, 0);
    chk("R5 ovf pulse", ovf_o, 1);
    chk("R5 status set", unc_status, 32'h4946);
    chk("R5 log kept", fep, 1);
    @(negedge clk);
    chk("R5 ovf one cycle", ovf_o, 0);
    clr(32'hFFFF_FFFF);
    chk("R5 dropped not queued", unc_status, 32'h0944);
    chk("R6 promote2", fep, 2);
    clr(32'hFFFF_FFFF);
    chk("R6 promote6", fep, 6);
    clr(32'hFFFF_FFFF);
    clr(32'hFFFF_FFFF);
    chk("R6 promote11", fep, 11);
    chk("R6 hdr11", hdr_log, mk(8'hA1, 8'd11));
    clr(32'hFFFF_FFFF);
    chk("R7 drained", unc_status, 0);
  endtask

  task automatic t_keep;
    mhr_en = 1; pfx_sup = 0;
    rec(4, 1, 0);
    rec(9, 1, 0);
    rec(13, 1, 0);
    clr(32'h200);
    chk("R8 on no effect", unc_status, 32'h2210);
    chk("R8 on fep", fep, 4);
    mhr_en = 0;
    clr(32'h2000);
    chk("R8 off status", unc_status, 32'h0210);
    mhr_en = 1;
    clr(32'h10);
    chk("R8 flushed fep", fep, 0);
    chk("R8 flushed hdr", hdr_log, 0);
    chk("R8 flushed status", unc_status, 32'h200);
    clr(32'h200);
    chk("R8 final", unc_status, 0);
  endtask

  task automatic t_bp;
    @(negedge clk);
    rec_valid = 1'b1; rec_status = 32'h0002_0000; rec_hdr_vld = 1'b1;
    rec_hdr = mk(8'hA1, 8'd17);
    clr_valid = 1'b1; clr_mask = '0;
    #1;
    chk("R10 ready low", rec_ready, 0);
    @(negedge clk);
    clr_valid = 1'b0; rec_valid = 1'b0; rec_hdr_vld = 1'b0;
    chk("R10 not accepted", unc_status, 0);
    chk("R10 log untouched", hdr_log, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_noflags();
    t_overwrite();
    t_queue();
    t_ovf();
    t_keep();
    t_bp();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule